// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Interval Refresh

This block sits between a simple word request port and an asynchronous-style DRAM with one shared, multiplexed address bus and active-low row strobe, column strobe and write-enable lines. A requester presents a word address, a direction and write data under valid/ready handshaking. The controller opens the addressed row by driving the row half of the address and lowering the row strobe. It then drives the column half and lowers the column strobe. Read data comes back as a single-cycle response pulse.

After an access the row stays open. A later request to the same row needs only a fresh column strobe, which saves the precharge and row-open cycles. A request to another row first closes the open row and holds the row strobe high for a precharge window.

A free-running interval timer raises a refresh demand. The controller serves that demand before any new request, but it always finishes an access that has already been accepted. A refresh closes the open row and issues a column-before-row strobe sequence. After reset the controller performs one refresh before it accepts any request. Every timing value is a parameter counted in clock cycles.

Top module: `pgdram_ctrl`

## Requirements
- R1: During reset and after it, the row strobe, column strobe and write enable stay high and `req_ready` stays low until the first refresh has been issued. The first falling edge of the row strobe belongs to a refresh.
- R2: The request address splits as row = upper `ROW_W` bits and column = lower `COL_W` bits. When no row is open, an access lowers the row strobe with the row on `dram_addr`, and the column strobe falls exactly `T_RCD` cycles later with the column on `dram_addr`.
- R3: A request whose row equals the open row produces only a column strobe pulse. The row strobe neither rises nor falls for that access.
- R4: Every time the row strobe falls, it has been high for at least `T_RP` cycles before, including when a request to a different row closes the open row.
- R5: A refresh demand arises every `REF_INTERVAL` cycles. Each refresh lowers the column strobe at least one cycle before the row strobe falls, and it leaves no row open afterwards.
- R6: A pending refresh wins over waiting requests. Under a continuous request stream, refreshes still occur about once per interval, and every accepted access still completes.
- R7: A read returns `rsp_valid` high for exactly one cycle. This happens in the cycle right after the last column strobe cycle, with the addressed word on `rsp_rdata`.
- R8: Write enable goes low only while both strobes are low during an access column phase. In that phase the write data is on `dram_dq_out` with `dram_dq_oe` high, and the word is stored at the addressed row and column.
- R9: An access column strobe pulse lasts exactly `T_CAS` cycles. A refresh column strobe stays low for exactly `T_RFC + 1` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The assertions check four things on every cycle:
- no request is accepted before the first refresh;
- the row strobe never falls without a full precharge window before it;
- a row strobe falling while the column strobe is low is always preceded by the column strobe already being low;
- write enable never leaves the strobed column phase, and read pulses never last two cycles.

Other properties can only be shown by the bench's scenarios against a behavioural memory model:
- data integrity over full address sweeps in row-major and column-major order;
- exact row-to-column delay and pulse widths;
- the absence of row strobe activity on page hits;
- refresh spacing, both idle and under a saturating request stream.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHG,
        ST_ROWSTB,
        ST_COLSTB,
        ST_RFCAS,
        ST_RFRAS,
        ST_RFREC
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/pgdram_ref_timer.sv
module pgdram_ref_timer #(
    parameter int unsigned INTERVAL = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import pgdram_pkg::*;

    localparam int unsigned TW = cnt_bits(INTERVAL - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= TW'(INTERVAL - 1);
        end else if (cnt == '0) begin
            cnt <= TW'(INTERVAL - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == '0) && !rst;

endmodule

// File: rtl/pgdram_row_track.sv
module pgdram_row_track #(
    parameter int unsigned ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             open_o,
    output logic             hit_o
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (clr) begin
            open_q <= 1'b0;
        end else if (set_en) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end
    end

    assign open_o = open_q;
    assign hit_o  = open_q && (row_q == cmp_row);

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq #(
    parameter int unsigned ROW_W  = 8,
    parameter int unsigned COL_W  = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned T_RP   = 3,
    parameter int unsigned T_RCD  = 2,
    parameter int unsigned T_CAS  = 2,
    parameter int unsigned T_RFC  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              row_open,
    input  logic              row_hit,
    output logic              row_set,
    output logic [ROW_W-1:0]  row_set_val,
    output logic              row_clr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              rd_cap
);
    import pgdram_pkg::*;

    localparam int unsigned TMAX = max2(max2(T_RP, T_RCD), max2(T_CAS, T_RFC));
    localparam int unsigned CW   = cnt_bits(TMAX);

    seq_state_e        st, st_n;
    logic [CW-1:0]     cnt, cnt_n;
    logic              pend, pend_n;
    logic              have, have_n;
    logic              lat_wr, lat_wr_n;
    logic [ROW_W-1:0]  lat_row, lat_row_n;
    logic [COL_W-1:0]  lat_col, lat_col_n;
    logic [DATA_W-1:0] lat_wd, lat_wd_n;
    logic              done;

    assign done = (cnt == '0);

    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        pend_n    = pend | ref_tick;
        have_n    = have;
        lat_wr_n  = lat_wr;
        lat_row_n = lat_row;
        lat_col_n = lat_col;
        lat_wd_n  = lat_wd;
        row_set   = 1'b0;
        row_clr   = 1'b0;
        rd_cap    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (pend) begin
                    if (row_open) begin
                        st_n    = ST_PRECHG;
                        cnt_n   = CW'(T_RP - 1);
                        row_clr = 1'b1;
                    end else begin
                        st_n   = ST_RFCAS;
                        pend_n = ref_tick;
                    end
                end else if (req_valid) begin
                    have_n    = 1'b1;
                    lat_wr_n  = req_wr;
                    lat_row_n = req_row;
                    lat_col_n = req_col;
                    lat_wd_n  = req_wdata;
                    if (row_hit) begin
                        st_n  = ST_COLSTB;
                        cnt_n = CW'(T_CAS - 1);
                    end else if (row_open) begin
                        st_n    = ST_PRECHG;
                        cnt_n   = CW'(T_RP - 1);
                        row_clr = 1'b1;
                    end else begin
                        st_n    = ST_ROWSTB;
                        cnt_n   = CW'(T_RCD - 1);
                        row_set = 1'b1;
                    end
                end
            end
            ST_PRECHG: begin
                if (!done) begin
                    cnt_n = cnt - 1'b1;
                end else if (have) begin
                    st_n    = ST_ROWSTB;
                    cnt_n   = CW'(T_RCD - 1);
                    row_set = 1'b1;
                end else begin
                    st_n   = ST_RFCAS;
                    pend_n = ref_tick;
                end
            end
            ST_ROWSTB: begin
                if (!done) begin
                    cnt_n = cnt - 1'b1;
                end else begin
                    st_n  = ST_COLSTB;
                    cnt_n = CW'(T_CAS - 1);
                end
            end
            ST_COLSTB: begin
                if (!done) begin
                    cnt_n = cnt - 1'b1;
                end else begin
                    st_n   = ST_IDLE;
                    have_n = 1'b0;
                    rd_cap = !lat_wr;
                end
            end
            ST_RFCAS: begin
                st_n  = ST_RFRAS;
                cnt_n = CW'(T_RFC - 1);
            end
            ST_RFRAS: begin
                if (!done) begin
                    cnt_n = cnt - 1'b1;
                end else begin
                    st_n  = ST_RFREC;
                    cnt_n = CW'(T_RP - 1);
                end
            end
            ST_RFREC: begin
                if (!done) begin
                    cnt_n = cnt - 1'b1;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            pend    <= 1'b1;
            have    <= 1'b0;
            lat_wr  <= 1'b0;
            lat_row <= '0;
            lat_col <= '0;
            lat_wd  <= '0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            pend    <= pend_n;
            have    <= have_n;
            lat_wr  <= lat_wr_n;
            lat_row <= lat_row_n;
            lat_col <= lat_col_n;
            lat_wd  <= lat_wd_n;
        end
    end

    assign row_set_val = (st == ST_IDLE) ? req_row : lat_row;
    assign req_ready   = (st == ST_IDLE) && !pend;
    assign ras_n = !((st == ST_IDLE && row_open) || st == ST_ROWSTB ||
                     st == ST_COLSTB || st == ST_RFRAS);
    assign cas_n = !(st == ST_COLSTB || st == ST_RFCAS || st == ST_RFRAS);
    assign we_n  = !(st == ST_COLSTB && lat_wr);
    assign addr  = (st == ST_COLSTB) ? ADDR_W'(lat_col) : ADDR_W'(lat_row);
    assign dq_o  = lat_wd;
    assign dq_oe = (st == ST_COLSTB) && lat_wr;

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
    parameter int unsigned ROW_W        = 8,
    parameter int unsigned COL_W        = 8,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned T_RP         = 3,
    parameter int unsigned T_RCD        = 2,
    parameter int unsigned T_CAS        = 2,
    parameter int unsigned T_RFC        = 4,
    parameter int unsigned REF_INTERVAL = 1000,
    localparam int unsigned ADDR_W      = pgdram_pkg::max2(ROW_W, COL_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]      dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);
    logic             ref_tick;
    logic             row_open, row_hit, row_set, row_clr, rd_cap;
    logic [ROW_W-1:0] row_set_val;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;

    assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    pgdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (ref_tick)
    );

    pgdram_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk     (clk),
        .rst     (rst),
        .set_en  (row_set),
        .set_row (row_set_val),
        .clr     (row_clr),
        .cmp_row (req_row),
        .open_o  (row_open),
        .hit_o   (row_hit)
    );

    pgdram_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RFC(T_RFC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ref_tick    (ref_tick),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_wr      (req_write),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_wdata   (req_wdata),
        .row_open    (row_open),
        .row_hit     (row_hit),
        .row_set     (row_set),
        .row_set_val (row_set_val),
        .row_clr     (row_clr),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .addr        (dram_addr),
        .dq_o        (dram_dq_out),
        .dq_oe       (dram_dq_oe),
        .rd_cap      (rd_cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_cap;
            if (rd_cap) begin
                rsp_rdata <= dram_dq_in;
            end
        end
    end

endmodule

// File: rtl/pgdram_ctrl_checker.sv
module pgdram_ctrl_checker #(
    parameter int unsigned T_RP = 3
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic rsp_valid,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n
);
    logic       seen_ref;
    logic [7:0] ras_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_ref <= 1'b0;
            ras_hi   <= 8'd0;
        end else begin
            if (!dram_ras_n && !dram_cas_n) begin
                seen_ref <= 1'b1;
            end
            if (!dram_ras_n) begin
                ras_hi <= 8'd0;
            end else if (ras_hi != 8'hFF) begin
                ras_hi <= ras_hi + 8'd1;
            end
        end
    end

    a_r1_no_accept_before_refresh: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> seen_ref);

    a_r4_precharge_window: assert property (@(posedge clk) disable iff (rst)
        (!dram_ras_n && ras_hi != 8'd0) |-> (ras_hi >= 8'(T_RP)));

    a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        (!dram_ras_n && !dram_cas_n && ras_hi != 8'd0) |-> $past(!dram_cas_n));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r8_we_in_column_phase: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> (!dram_cas_n && !dram_ras_n));

endmodule

bind pgdram_ctrl pgdram_ctrl_checker #(.T_RP(T_RP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n)
);

// File: tb/pgdram_ctrl_bench.sv
module pgdram_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int DATA_W = 8;
    localparam int T_RP = 2;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_RFC = 3;
    localparam int REF_INTERVAL = 200;
    localparam int AW = ROW_W + COL_W;
    localparam int NWORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [2:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [DATA_W-1:0] dram_dq_out, dram_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgdram_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RP(T_RP),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL)
    ) u_pgdram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural memory model
    logic [DATA_W-1:0] mem [NWORDS];
    logic [ROW_W-1:0] m_row = '0;
    logic [COL_W-1:0] m_col = '0;
    assign dram_dq_in = mem[{m_row, m_col}];

    int cyc = 0;
    int ref_cnt = 0;
    int last_ref = 0;
    int acc_open = 0;
    int ras_rise = 0;
    int since_ras = 0;
    int ras_hi = 0;
    int cas_lo = 0;
    bit fresh = 0;
    bit prev_ras = 1, prev_cas = 1, prev_rv = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_ras = 1; prev_cas = 1; prev_rv = 0;
        end else if (!finished) begin
            cyc++;
            if (prev_ras && !dram_ras_n) begin
                if (!prev_cas) begin
                    ref_cnt++;
                    check(!dram_cas_n, "R5 cas low through refresh row strobe", dram_cas_n, 0);
                    if (ref_cnt > 1)
                        check((cyc - last_ref) >= REF_INTERVAL - 15 &&
                              (cyc - last_ref) <= REF_INTERVAL + 15,
                              "R5 refresh spacing", cyc - last_ref, REF_INTERVAL);
                    last_ref = cyc;
                end else begin
                    acc_open++;
                    check(ref_cnt > 0, "R1 refresh before first access", ref_cnt, 1);
                    check(ras_hi >= T_RP, "R4 precharge before row open", ras_hi, T_RP);
                    m_row = dram_addr[ROW_W-1:0];
                    fresh = 1;
                end
            end
            if (!prev_ras && dram_ras_n) ras_rise++;
            if (prev_cas && !dram_cas_n && !prev_ras && !dram_ras_n) begin
                m_col = dram_addr[COL_W-1:0];
                if (fresh) check(since_ras + 1 == T_RCD, "R2 row-to-column delay", since_ras + 1, T_RCD);
                fresh = 0;
                if (!dram_we_n) begin
                    check(dram_dq_oe, "R8 data enable during write", dram_dq_oe, 1);
                    mem[{m_row, m_col}] = dram_dq_out;
                end
            end
            if (!prev_cas && dram_cas_n) begin
                if (!dram_ras_n) check(cas_lo == T_CAS, "R9 access column pulse width", cas_lo, T_CAS);
                else check(cas_lo == T_RFC + 1, "R9 refresh column pulse width", cas_lo, T_RFC + 1);
            end
            if (!dram_we_n && (dram_cas_n || dram_ras_n))
                check(0, "R8 write enable outside column phase", dram_we_n, 1);
            if (req_ready && ref_cnt == 0)
                check(0, "R1 ready before first refresh", req_ready, 0);
            if (rsp_valid) begin
                check(!prev_rv, "R7 response one cycle", prev_rv, 0);
                check(!prev_cas && dram_cas_n, "R7 response right after column pulse", prev_cas, 0);
            end
            if (prev_ras && !dram_ras_n) since_ras = 0; else since_ras++;
            if (dram_ras_n) ras_hi++; else ras_hi = 0;
            if (!dram_cas_n) cas_lo++; else cas_lo = 0;
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_rv = rsp_valid;
        end
    end

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a * 29 + 7 + k * 101) & 255);
    endfunction

    task automatic issue(input bit wr, input int a, input logic [7:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = AW'(a);
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_check(input int a, input logic [7:0] exp, input string tag);
        int waited = 0;
        issue(0, a, 8'h00);
        while (!rsp_valid && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        check(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0, r0, a0, rr0;
        for (int i = 0; i < NWORDS; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset",
              {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        check(!req_ready, "R1 no ready in reset", req_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!req_ready, "R1 no ready right after reset", req_ready, 0);
        while (ref_cnt == 0) @(negedge clk);
        repeat (10) @(negedge clk);

        // R3 page hit after a miss
        issue(1, (2 << COL_W) | 1, 8'hA1);
        repeat (6) @(negedge clk);
        a0 = acc_open; rr0 = ras_rise;
        issue(1, (2 << COL_W) | 5, 8'hB5);
        repeat (6) @(negedge clk);
        check(acc_open == a0, "R3 no row open on hit", acc_open, a0);
        check(ras_rise == rr0, "R3 row strobe held on hit", ras_rise, rr0);
        issue(1, (5 << COL_W), 8'hC0);
        repeat (8) @(negedge clk);
        check(acc_open == a0 + 1, "R4 mismatch reopens row", acc_open, a0 + 1);
        read_check((2 << COL_W) | 5, 8'hB5, "R8 directed write stored");

        // R6 saturating row-major write stream
        c0 = cyc; r0 = ref_cnt;
        for (int a = 0; a < NWORDS; a++) begin
            req_valid = 1'b1;
            issue(1, a, pat(a, 0));
        end
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < NWORDS; a++) issue(1, a, pat(a, 0));
        repeat (8) @(negedge clk);
        check((ref_cnt - r0) >= (cyc - c0) / REF_INTERVAL - 1, "R6 refresh under stream",
              ref_cnt - r0, (cyc - c0) / REF_INTERVAL);

        // R7/R2 column-major read sweep, every access a row change
        for (int c = 0; c < (1 << COL_W); c++)
            for (int r = 0; r < (1 << ROW_W); r++)
                read_check((r << COL_W) | c, pat((r << COL_W) | c, 0), "R7 column-major read");

        // R5 idle refresh rate
        r0 = ref_cnt;
        repeat (1000) @(negedge clk);
        check((ref_cnt - r0) >= 4 && (ref_cnt - r0) <= 6, "R5 idle refresh count", ref_cnt - r0, 5);

        // R8 partial rewrite, R3 row-major read back
        for (int a = 0; a < NWORDS; a += 2) issue(1, a, pat(a, 1));
        for (int a = 0; a < NWORDS; a++)
            read_check(a, pat(a, a % 2 == 0 ? 1 : 0), "R8 rewrite read back");

        repeat (5) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule